// File: doc/BRIEF.md
# Bus-Mastering DMA Engine

This block moves a block of words from a device data port into memory without the processor touching each word. Software loads a start address and a word count through a small register port, then writes a control word whose start bit launches the copy and whose mode bit picks how the bus is shared. The engine raises a bus request, waits for the processor's grant, and only then drives address, data and write strobe onto the shared memory bus. At all other times those lines float.

In continuous mode the whole block moves in a single bus tenure, one word per memory cycle. In cycle-steal mode the engine takes one word per grant and hands the bus back after each word. The processor issues such grants at its own instruction boundaries. When the count reaches zero and the last grant has been withdrawn, the engine flags completion in its status register and holds an interrupt request until software writes the control register again.

Top module: `dma_engine`

## Requirements
- R1: After reset, bus_req, irq, mem_oe and dev_ack are 0. mem_addr, mem_wdata and mem_we are high-impedance. The status register reads 0.
- R2: The register port uses cfg_sel 0 for the memory address, 1 for the word count, 2 for control (bit 0 start, bit 1 mode: 0 continuous, 1 cycle-steal) and 3 for status (bit 0 busy, bit 1 done). A read returns the selected value combinationally. Writing control with bit 0 set starts a transfer.
- R3: mem_oe is 1 only while bus_gnt is 1. Whenever bus_gnt is 0, mem_addr, mem_wdata and mem_we are high-impedance.
- R4: Continuous mode moves all words in one grant tenure. If the device is not ready, bus_req and mem_oe stay 1 while the engine waits.
- R5: Cycle-steal mode writes at most one word per grant tenure, so N words take N tenures. While the device is not ready, bus_req stays 0.
- R6: Each word taken from the device (dev_valid and dev_ack both 1) is written with mem_we=1 to the current address, in device order. Afterwards the address register has risen by one and the count register has fallen by one.
- R7: After the last word, bus_req falls. Once bus_gnt is 0, the engine goes idle, sets done and raises irq.
- R8: A start with a count of 0 completes without raising bus_req. irq is 1 one cycle after the write.
- R9: Writes to the address, count or control registers have no effect while busy is 1.
- R10: While idle, a write to control clears done and irq. With bit 0 clear, that write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_oe | output | 1 | High while the engine drives the memory bus |
| mem_addr | output | AW | Memory address, high-impedance when not driving |
| mem_wdata | output | DW | Memory write data, high-impedance when not driving |
| mem_we | output | 1 | Memory write strobe, high-impedance when not driving |
| dev_valid | input | 1 | Device has a word ready |
| dev_data | input | DW | Device word |
| dev_ack | output | 1 | Device word consumed this cycle |
| irq | output | 1 | Completion interrupt request |

## Verification
The assertions check on every cycle that the engine never drives the bus without the grant, that the request stays up while the bus is owned, and that a write always steps the address. They also check that a cycle-steal tenure ends after its single word, that register contents stay frozen while busy apart from the transfer itself, and that irq only appears once the engine is idle. Only the bench's scenarios can show the rest. That covers word order and addresses against the device stream, and the tenure count in each mode. It also covers holding versus releasing the bus when the device stalls, the zero-count start, and the clearing of irq by a control write.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_OWN,
        ST_REL
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STEAL_BIT = 1;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_DONE_BIT  = 1;
endpackage

// File: rtl/dma_core.sv
module dma_core
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [RW-1:0] cfg_wdata,
    input  logic          bus_gnt,
    input  logic          dev_valid,
    output logic          bus_req,
    output logic          own_bus,
    output logic          wr_strobe,
    output logic          dev_ack,
    output logic          irq,
    output logic          busy,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o,
    output logic          steal_o,
    output logic          done_o
);
    localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CNT_ONE  = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        dma_state_e    st;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          steal;
        logic          done;
    } core_t;

    core_t q, d;
    logic  take_word;

    assign take_word = (q.st == ST_OWN) && dev_valid;

    always_comb begin
        d = q;
        if (q.st == ST_IDLE && cfg_we) begin
            case (cfg_sel)
                SEL_ADDR: d.addr = cfg_wdata[AW-1:0];
                SEL_CNT:  d.cnt  = cfg_wdata[CW-1:0];
                SEL_CTRL: begin
                    d.done  = 1'b0;
                    d.steal = cfg_wdata[CTRL_STEAL_BIT];
                    if (cfg_wdata[CTRL_START_BIT]) begin
                        if (q.cnt == '0)
                            d.done = 1'b1;
                        else if (cfg_wdata[CTRL_STEAL_BIT])
                            d.st = ST_WAIT;
                        else
                            d.st = ST_REQ;
                    end
                end
                default: ;
            endcase
        end
        case (q.st)
            ST_WAIT: if (dev_valid) d.st = ST_REQ;
            ST_REQ:  if (bus_gnt) d.st = ST_OWN;
            ST_OWN: begin
                if (dev_valid) begin
                    d.addr = q.addr + ADDR_ONE;
                    d.cnt  = q.cnt - CNT_ONE;
                    if (q.cnt == CNT_ONE || q.steal) d.st = ST_REL;
                end
            end
            ST_REL: begin
                if (!bus_gnt) begin
                    if (q.cnt == '0) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.addr  <= '0;
            q.cnt   <= '0;
            q.steal <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign bus_req   = (q.st == ST_REQ) || (q.st == ST_OWN);
    assign own_bus   = (q.st == ST_OWN);
    assign wr_strobe = take_word;
    assign dev_ack   = take_word;
    assign irq       = q.done;
    assign busy      = (q.st != ST_IDLE);
    assign addr_o    = q.addr;
    assign cnt_o     = q.cnt;
    assign steal_o   = q.steal;
    assign done_o    = q.done;

    AST_OWN_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        own_bus |-> bus_gnt);  // R3
    AST_REQ_WHILE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        own_bus |-> bus_req);  // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> (addr_o == $past(addr_o) + ADDR_ONE));  // R6
    AST_STEAL_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && steal_o) |=> !own_bus);  // R5
    AST_LOCK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_strobe) |=> ($stable(cnt_o) && $stable(addr_o) && $stable(steal_o)));  // R9
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);  // R7
endmodule

// File: rtl/dma_csr_read.sv
module dma_csr_read
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] addr_q,
    input  logic [CW-1:0] cnt_q,
    input  logic          steal_q,
    input  logic          busy,
    input  logic          done_q,
    output logic [RW-1:0] cfg_rdata
);
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_ADDR: cfg_rdata[AW-1:0] = addr_q;
            SEL_CNT:  cfg_rdata[CW-1:0] = cnt_q;
            SEL_CTRL: cfg_rdata[CTRL_STEAL_BIT] = steal_q;
            SEL_STAT: begin
                cfg_rdata[STAT_BUSY_BIT] = busy;
                cfg_rdata[STAT_DONE_BIT] = done_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_oe,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic          dev_valid,
    input  logic [DW-1:0] dev_data,
    output logic          dev_ack,
    output logic          irq
);
    logic          own_bus;
    logic          wr_strobe;
    logic          busy;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          steal_q;
    logic          done_q;

    dma_core #(.AW(AW), .CW(CW), .RW(RW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .bus_gnt   (bus_gnt),
        .dev_valid (dev_valid),
        .bus_req   (bus_req),
        .own_bus   (own_bus),
        .wr_strobe (wr_strobe),
        .dev_ack   (dev_ack),
        .irq       (irq),
        .busy      (busy),
        .addr_o    (addr_q),
        .cnt_o     (cnt_q),
        .steal_o   (steal_q),
        .done_o    (done_q)
    );

    dma_csr_read #(.AW(AW), .CW(CW), .RW(RW)) u_rd (
        .cfg_sel   (cfg_sel),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .steal_q   (steal_q),
        .busy      (busy),
        .done_q    (done_q),
        .cfg_rdata (cfg_rdata)
    );

    assign mem_oe    = own_bus;
    assign mem_addr  = own_bus ? addr_q   : {AW{1'bz}};
    assign mem_wdata = own_bus ? dev_data : {DW{1'bz}};
    assign mem_we    = own_bus ? wr_strobe : 1'bz;

    AST_FLOAT_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> !mem_oe);  // R3
    AST_ACK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (mem_oe && dev_valid));  // R6
endmodule

// File: tb/dma_engine_bench.sv
module dma_engine_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int RW = 32;
    localparam int GDLY = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          bus_req;
    logic          bus_gnt;
    logic          mem_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          dev_valid;
    logic [DW-1:0] dev_data;
    logic          dev_ack;
    logic          irq;

    always #4 clk = ~clk;

    dma_engine #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) u_dma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_oe(mem_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .dev_valid(dev_valid),
        .dev_data(dev_data), .dev_ack(dev_ack), .irq(irq)
    );

    int nvec = 0;
    int nmis = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nmis++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // processor grant model
    int gdly;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
            gdly    <= 0;
        end else if (bus_req && !bus_gnt) begin
            if (gdly == GDLY) begin
                bus_gnt <= 1'b1;
                gdly    <= 0;
            end else begin
                gdly <= gdly + 1;
            end
        end else if (!bus_req) begin
            bus_gnt <= 1'b0;
        end
    end

    // device model
    logic dev_hold = 1'b0;
    int   dev_idx = 0;
    function automatic logic [DW-1:0] dev_word(input int idx);
        return 32'hA500_0000 + DW'(idx * 7);
    endfunction
    assign dev_valid = !dev_hold;
    assign dev_data  = dev_word(dev_idx);
    always @(posedge clk) if (dev_ack) dev_idx <= dev_idx + 1;

    // scoreboard
    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] w;
    } exp_t;
    exp_t exp_q[$];
    int   tenures = 0, cur_w = 0, max_w = 0;
    bit   prev_gnt = 0, req_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) req_seen = 1;
            if (mem_we === 1'b1) begin
                cur_w++;
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected write", longint'(mem_addr), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(mem_addr == e.a, "R6 address", longint'(mem_addr), longint'(e.a));
                    chk(mem_wdata == e.w, "R6 data", longint'(mem_wdata), longint'(e.w));
                end
            end
            if (!bus_gnt) begin
                chk(mem_addr === {AW{1'bz}} && mem_we === 1'bz && mem_wdata === {DW{1'bz}},
                    "R3 lines float without grant", longint'(mem_oe), 0);
            end
            if (prev_gnt && !bus_gnt) begin
                tenures++;
                if (cur_w > max_w) max_w = cur_w;
                cur_w = 0;
            end
            prev_gnt = bus_gnt;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [RW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [RW-1:0] v);
        @(negedge clk);
        cfg_sel = sel;
        #1 v = cfg_rdata;
    endtask

    task automatic start(input logic [AW-1:0] a, input int n, input bit steal);
        tenures = 0; cur_w = 0; max_w = 0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = a + AW'(i);
            e.w = dev_word(dev_idx + i);
            exp_q.push_back(e);
        end
        wr(2'd0, RW'(a));
        wr(2'd1, RW'(n));
        wr(2'd2, {30'd0, steal, 1'b1});
    endtask

    task automatic wait_irq(input string req);
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(irq == 1'b1, req, longint'(irq), 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nmis++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        @(negedge clk);
        chk(!bus_req && !irq && !mem_oe && !dev_ack, "R1 reset outputs", longint'({bus_req, irq, mem_oe}), 0);
        chk(mem_addr === {AW{1'bz}}, "R1 reset float", longint'(mem_addr), 0);
        rd(2'd3, v);
        chk(v == 0, "R1 reset status", longint'(v), 0);

        // R2 register readback
        wr(2'd0, 32'h0040);
        wr(2'd1, 32'd5);
        rd(2'd0, v); chk(v == 32'h40, "R2 address readback", longint'(v), 32'h40);
        rd(2'd1, v); chk(v == 32'd5, "R2 count readback", longint'(v), 5);

        // R4 R6 R7 continuous, device always ready
        start(16'h0040, 5, 1'b0);
        rd(2'd3, v); chk(v[0] == 1'b1, "R2 busy bit", longint'(v), 1);
        wait_irq("R7 irq after continuous");
        chk(tenures == 1, "R4 single tenure", longint'(tenures), 1);
        rd(2'd0, v); chk(v == 32'h45, "R6 address advanced", longint'(v), 32'h45);
        rd(2'd1, v); chk(v == 0, "R6 count at zero", longint'(v), 0);
        rd(2'd3, v); chk(v == 32'h2, "R7 status done, not busy", longint'(v), 2);

        // R10 control write without start clears irq
        wr(2'd2, 32'h0);
        chk(irq == 1'b0, "R10 irq cleared", longint'(irq), 0);
        rd(2'd3, v); chk(v == 0, "R10 status cleared", longint'(v), 0);
        repeat (4) @(negedge clk);
        chk(bus_req == 1'b0, "R10 no start without bit 0", longint'(bus_req), 0);

        // R4 stall holds bus, R9 writes while busy ignored
        dev_hold = 1'b1;
        start(16'h0100, 4, 1'b0);
        repeat (10) @(negedge clk);
        chk(bus_req && mem_oe, "R4 bus held during stall", longint'({bus_req, mem_oe}), 3);
        wr(2'd0, 32'h0999);
        wr(2'd1, 32'd7);
        wr(2'd2, 32'h3);
        dev_hold = 1'b0;
        @(negedge clk); dev_hold = 1'b1;
        repeat (3) @(negedge clk); dev_hold = 1'b0;
        wait_irq("R7 irq after stalled continuous");
        chk(tenures == 1, "R4 single tenure with stalls", longint'(tenures), 1);
        rd(2'd0, v); chk(v == 32'h104, "R9 address write ignored", longint'(v), 32'h104);
        rd(2'd1, v); chk(v == 0, "R9 count write ignored", longint'(v), 0);
        rd(2'd2, v); chk(v == 0, "R9 mode write ignored", longint'(v), 0);

        // R5 cycle-steal
        dev_hold = 1'b1;
        req_seen = 0;
        start(16'h0200, 3, 1'b1);
        repeat (8) @(negedge clk);
        chk(!req_seen, "R5 no request while device idle", longint'(req_seen), 0);
        dev_hold = 1'b0;
        wait_irq("R7 irq after cycle-steal");
        chk(tenures == 3, "R5 one tenure per word", longint'(tenures), 3);
        chk(max_w == 1, "R5 one word per tenure", longint'(max_w), 1);
        rd(2'd0, v); chk(v == 32'h203, "R6 steal address advanced", longint'(v), 32'h203);

        // R8 zero count
        wr(2'd2, 32'h0);
        req_seen = 0;
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h1);
        chk(irq == 1'b1, "R8 irq right after zero-count start", longint'(irq), 1);
        repeat (4) @(negedge clk);
        chk(!req_seen, "R8 no bus request", longint'(req_seen), 0);

        // single-word boundary
        wr(2'd2, 32'h0);
        start(16'hFFFF, 1, 1'b0);
        wait_irq("R7 irq after one word");
        rd(2'd0, v); chk(v == 32'h0, "R6 address wraps", longint'(v), 0);
        chk(exp_q.size() == 0, "R6 all words written", longint'(exp_q.size()), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule